// File: doc/BRIEF.md
# Audio Port Register Block

This block is the bus-facing register set of a serial audio port. Software sees three 32-bit registers: control, status and a data window. Each register has three write addresses. The first writes the value as given. The second ORs the value into the register. The third clears every bit that is written as 1. With these, software can change single bits without a read-modify-write. The serial engine and the bit clock divider sit outside this block. They get the control fields as outputs, report their activity on an input, and move samples through two 32-bit FIFOs: transmit towards the engine and receive from it.

The control register holds a soft reset bit and a clock gate bit, and both are set out of reset. While either one is set, only those two bits can change. The data window is also closed: writes to it are dropped and reads of it return zero. The status register shows a busy flag, two sticky FIFO error flags and the fill level of each FIFO. An interrupt line is raised when error reporting is enabled and either error flag is set. The 2-bit word length field tells the engine how many FIFO words make one stereo frame. At 16 bits one word carries both channels, with the left channel in the low half. At 20 or 24 bits each word carries one channel.

Address map: bits [5:4] select the register (0 control, 1 status, 2 data). Bits [3:2] select the access (0 plain, 1 set, 2 clear, 3 ignored). Read data is registered and appears on the cycle after the read request.

Top module: `audio_port_regs`

## Requirements
- R1: After reset, control reads 0xC000_0000 (bit 31 soft reset, bit 30 clock gate), status reads 0, irq_o is 0, clk_en_o is 0 and eng_rst_o is 1.
- R2: A control write at offset 0x00 loads the value, at 0x04 ORs it in, and at 0x08 clears the bits written as 1. A write at 0x0C changes nothing. Control bits 29:9 and 3 always read 0.
- R3: While control bit 31 or bit 30 is set, a control write can change only bits 31:30. Bits 29:0 keep their value.
- R4: Status bit 0 (busy) reads 1 while control bit 0 (run) is set or eng_active_i is high, and reads 0 otherwise.
- R5: Status bit 1 (underflow) is set when tx_pop_i is high while the transmit FIFO is empty. Status bit 2 (overflow) is set when rx_push_i is high while the receive FIFO is full. Both flags stay set until a 1 is written to their bit at status offset 0x18. Writes to status at 0x10 or 0x14 have no effect. A flag that is set by hardware in the same cycle as a clear write ends up set.
- R6: irq_o is high exactly when control bit 2 (error interrupt enable) is set and status bit 1 or bit 2 is set.
- R7: A write at offset 0x20 pushes a word into the transmit FIFO. The engine sees the words on tx_data_o in the order they were written, and tx_data_o is 0 when the FIFO is empty. A write to a full FIFO is dropped. Status bits 15:8 give the transmit fill level.
- R8: A read at offset 0x20 returns the oldest receive word and removes it. A read of an empty receive FIFO returns 0. Status bits 23:16 give the receive fill level.
- R9: One cycle after control bit 31 becomes set, both FIFOs are empty and both error flags are clear. They stay that way while bit 31 remains set.
- R10: frame_words_o is 1 when control bits 5:4 (word length) are 0, meaning 16 bits with both channels in one word. It is 2 for the codes 1 (20 bits) and 2 (24 bits), and for the reserved code 3.
- R11: run_o follows control bit 0, rx_mode_o bit 1, bclk_edge_o bit 6, frame_pol_o bit 7 and data_delay_o bit 8. clk_en_o is the inverse of bit 30, and eng_rst_o follows bit 31.
- R12: While control bit 31 or bit 30 is set, a write at 0x20 pushes nothing. A read at 0x20 returns 0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 6 | Byte address: register select in bits [5:4], access kind in bits [3:2] |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid on the cycle after the read |
| irq_o | output | 1 | FIFO error interrupt |
| run_o | output | 1 | Engine run enable |
| rx_mode_o | output | 1 | 1 for receive direction, 0 for transmit |
| word_len_o | output | 2 | Sample word length code |
| frame_words_o | output | 2 | FIFO words per stereo frame |
| bclk_edge_o | output | 1 | Bit clock sampling edge select |
| frame_pol_o | output | 1 | Frame clock polarity |
| data_delay_o | output | 1 | One-bit data delay after the frame edge |
| clk_en_o | output | 1 | Clock enable for the engine and divider |
| eng_rst_o | output | 1 | Reset to the engine |
| eng_active_i | input | 1 | Engine has frames in flight |
| tx_pop_i | input | 1 | Engine takes one transmit word |
| tx_data_o | output | 32 | Head of the transmit FIFO |
| tx_empty_o | output | 1 | Transmit FIFO is empty |
| rx_push_i | input | 1 | Engine delivers one receive word |
| rx_data_i | input | 32 | Receive word from the engine |
| rx_full_o | output | 1 | Receive FIFO is full |

## Verification
The bench goes after the lock on the control register while soft reset or gating is set. A design that ignored the lock would let field bits change during reset, or let a plain write of zero leave stale fields behind. It checks each flag when a set and a clear arrive in the same cycle, and that writes to the plain and set addresses of status do nothing. A design that got either wrong would lose an underflow, or let software clear a flag by accident. It also fills both FIFOs past full, reads the receive FIFO when it is empty, and confirms that soft reset empties both FIFOs. A wrong design would wrap its pointers and then replay stale samples or return junk instead of zero.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // control bit positions
  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_RXM   = 1;
  localparam int unsigned CB_ERRIE = 2;
  localparam int unsigned CB_WL    = 4;
  localparam int unsigned CB_EDGE  = 6;
  localparam int unsigned CB_POL   = 7;
  localparam int unsigned CB_DLY   = 8;
  localparam int unsigned CB_GATE  = 30;
  localparam int unsigned CB_SRST  = 31;

  // status bit positions
  localparam int unsigned SB_BUSY  = 0;
  localparam int unsigned SB_UF    = 1;
  localparam int unsigned SB_OF    = 2;
  localparam int unsigned SB_TXCNT = 8;
  localparam int unsigned SB_RXCNT = 16;
  localparam int unsigned CNT_FLD_W = 8;

  localparam logic [REG_W-1:0] CTRL_MASK  = 32'hC000_01F7;
  localparam logic [REG_W-1:0] CTRL_RESET = 32'hC000_0000;
  localparam logic [REG_W-1:0] LOCK_KEEP  = 32'h3FFF_FFFF;

  function automatic logic [REG_W-1:0] apply_access(acc_e acc, logic [REG_W-1:0] cur,
                                                     logic [REG_W-1:0] wd);
    logic [REG_W-1:0] nxt;
    unique case (acc)
      ACC_PLAIN: nxt = wd;
      ACC_SET:   nxt = cur | wd;
      ACC_CLR:   nxt = cur & ~wd;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/apc_fifo.sv
module apc_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign dout_o  = empty_o ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/apc_ctrl_reg.sv
module apc_ctrl_reg
  import audio_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  acc_e             acc_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_d, upd;
  logic locked;

  assign locked = ctrl_q[CB_SRST] | ctrl_q[CB_GATE];

  always_comb begin
    upd = apply_access(acc_i, ctrl_q, wdata_i) & CTRL_MASK;
    if (locked) upd = (upd & ~LOCK_KEEP) | (ctrl_q & LOCK_KEEP);
    ctrl_d = wr_i ? upd : ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RESET;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/apc_err_flags.sv
module apc_err_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic uf_set_i,
  input  logic of_set_i,
  input  logic clr_wr_i,
  input  logic uf_clr_i,
  input  logic of_clr_i,
  output logic uf_o,
  output logic of_o
);
  logic uf_q, of_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q <= 1'b0;
      of_q <= 1'b0;
    end else if (srst_i) begin
      uf_q <= 1'b0;
      of_q <= 1'b0;
    end else begin
      // hardware set wins over a same-cycle clear
      uf_q <= uf_set_i | (uf_q & ~(clr_wr_i & uf_clr_i));
      of_q <= of_set_i | (of_q & ~(clr_wr_i & of_clr_i));
    end
  end

  assign uf_o = uf_q;
  assign of_o = of_q;
endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
  import audio_port_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_valid_i,
  input  logic        bus_write_i,
  input  logic [5:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o,
  output logic        run_o,
  output logic        rx_mode_o,
  output logic [1:0]  word_len_o,
  output logic [1:0]  frame_words_o,
  output logic        bclk_edge_o,
  output logic        frame_pol_o,
  output logic        data_delay_o,
  output logic        clk_en_o,
  output logic        eng_rst_o,
  input  logic        eng_active_i,
  input  logic        tx_pop_i,
  output logic [31:0] tx_data_o,
  output logic        tx_empty_o,
  input  logic        rx_push_i,
  input  logic [31:0] rx_data_i,
  output logic        rx_full_o
);
  reg_sel_e sel;
  acc_e     acc;
  logic [REG_W-1:0] ctrl_q, stat_word, rd_mux, rdata_q;
  logic ctrl_wr, stat_clr, tx_push, rx_pop, rd_req, locked;
  logic uf_q, of_q, tx_full, rx_empty;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [REG_W-1:0] rx_head;

  assign sel    = reg_sel_e'(bus_addr_i[5:4]);
  assign acc    = acc_e'(bus_addr_i[3:2]);
  assign locked = ctrl_q[CB_SRST] | ctrl_q[CB_GATE];
  assign rd_req = bus_valid_i & ~bus_write_i;

  assign ctrl_wr  = bus_valid_i & bus_write_i & (sel == REG_CTRL);
  assign stat_clr = bus_valid_i & bus_write_i & (sel == REG_STAT) & (acc == ACC_CLR);
  assign tx_push  = bus_valid_i & bus_write_i & (sel == REG_DATA) & (acc == ACC_PLAIN) & ~locked;
  assign rx_pop   = rd_req & (sel == REG_DATA) & (acc == ACC_PLAIN) & ~locked;

  apc_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .acc_i   (acc),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  apc_err_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (ctrl_q[CB_SRST]),
    .uf_set_i (tx_pop_i & tx_empty_o),
    .of_set_i (rx_push_i & tx_full_dummy_n(rx_full_o)),
    .clr_wr_i (stat_clr),
    .uf_clr_i (bus_wdata_i[SB_UF]),
    .of_clr_i (bus_wdata_i[SB_OF]),
    .uf_o     (uf_q),
    .of_o     (of_q)
  );

  function automatic logic tx_full_dummy_n(logic v);
    return v;
  endfunction

  apc_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(REG_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ctrl_q[CB_SRST]),
    .push_i  (tx_push),
    .din_i   (bus_wdata_i),
    .pop_i   (tx_pop_i),
    .dout_o  (tx_data_o),
    .full_o  (tx_full),
    .empty_o (tx_empty_o),
    .count_o (tx_cnt)
  );

  apc_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(REG_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ctrl_q[CB_SRST]),
    .push_i  (rx_push_i),
    .din_i   (rx_data_i),
    .pop_i   (rx_pop),
    .dout_o  (rx_head),
    .full_o  (rx_full_o),
    .empty_o (rx_empty),
    .count_o (rx_cnt)
  );

  always_comb begin
    stat_word = '0;
    stat_word[SB_BUSY] = ctrl_q[CB_RUN] | eng_active_i;
    stat_word[SB_UF]   = uf_q;
    stat_word[SB_OF]   = of_q;
    stat_word[SB_TXCNT +: CNT_FLD_W] = CNT_FLD_W'(tx_cnt);
    stat_word[SB_RXCNT +: CNT_FLD_W] = CNT_FLD_W'(rx_cnt);
  end

  always_comb begin
    unique case (sel)
      REG_CTRL: rd_mux = ctrl_q;
      REG_STAT: rd_mux = stat_word;
      REG_DATA: rd_mux = rx_pop ? rx_head : '0;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_mux;
  end

  assign bus_rdata_o   = rdata_q;
  assign irq_o         = ctrl_q[CB_ERRIE] & (uf_q | of_q);
  assign run_o         = ctrl_q[CB_RUN];
  assign rx_mode_o     = ctrl_q[CB_RXM];
  assign word_len_o    = ctrl_q[CB_WL +: 2];
  assign frame_words_o = (ctrl_q[CB_WL +: 2] == 2'd0) ? 2'd1 : 2'd2;
  assign bclk_edge_o   = ctrl_q[CB_EDGE];
  assign frame_pol_o   = ctrl_q[CB_POL];
  assign data_delay_o  = ctrl_q[CB_DLY];
  assign clk_en_o      = ~ctrl_q[CB_GATE];
  assign eng_rst_o     = ctrl_q[CB_SRST];
endmodule

// File: rtl/audio_port_regs_chk.sv
module audio_port_regs_chk #(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_valid_i,
  input logic             bus_write_i,
  input logic [5:0]       bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic [31:0]      bus_rdata_o,
  input logic [31:0]      ctrl_q,
  input logic             uf_q,
  input logic             of_q,
  input logic             irq_o,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt
);
  logic clr_hit, lock_now, data_rd;
  assign clr_hit  = bus_valid_i & bus_write_i & (bus_addr_i[5:2] == 4'b0110);
  assign lock_now = ctrl_q[31] | ctrl_q[30];
  assign data_rd  = bus_valid_i & ~bus_write_i & (bus_addr_i[5:2] == 4'b1000);

  a_r3_lock_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_now |=> (ctrl_q[29:0] == $past(ctrl_q[29:0])));

  a_r5_uf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_q && !ctrl_q[31] && !(clr_hit && bus_wdata_i[1])) |=> uf_q);

  a_r5_of_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_q && !ctrl_q[31] && !(clr_hit && bus_wdata_i[2])) |=> of_q);

  a_r6_irq_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ctrl_q[2] & (uf_q | of_q)));

  a_r7_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt <= CNT_W'(FIFO_DEPTH)) && (rx_cnt <= CNT_W'(FIFO_DEPTH)));

  a_r8_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && rx_cnt == '0) |=> (bus_rdata_o == 32'h0));

  a_r9_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[31] |=> (tx_cnt == '0 && rx_cnt == '0 && !uf_q && !of_q));
endmodule

bind audio_port_regs audio_port_regs_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .ctrl_q      (ctrl_q),
  .uf_q        (uf_q),
  .of_q        (of_q),
  .irq_o       (irq_o),
  .tx_cnt      (tx_cnt),
  .rx_cnt      (rx_cnt)
);

// File: tb/sim_audio_port_regs.sv
module sim_audio_port_regs;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic clk = 0, rst_ni = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, run, rx_mode, bclk_edge, frame_pol, data_delay, clk_en, eng_rst;
  logic [1:0] word_len, frame_words;
  logic eng_active = 0, tx_pop = 0, rx_push = 0;
  logic [31:0] tx_data, rx_data = '0;
  logic tx_empty, rx_full;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_port_regs #(.FIFO_DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .run_o(run), .rx_mode_o(rx_mode), .word_len_o(word_len),
    .frame_words_o(frame_words), .bclk_edge_o(bclk_edge), .frame_pol_o(frame_pol),
    .data_delay_o(data_delay), .clk_en_o(clk_en), .eng_rst_o(eng_rst),
    .eng_active_i(eng_active), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .tx_empty_o(tx_empty), .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_full_o(rx_full)
  );

  // model state
  logic [31:0] m_ctrl;
  logic [31:0] m_tx [D];
  logic [31:0] m_rx [D];
  int m_txn, m_rxn;
  logic m_uf, m_of;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic push_rx(logic [31:0] d);
    @(negedge clk); rx_push = 1; rx_data = d;
    @(negedge clk); rx_push = 0;
  endtask

  function automatic logic [31:0] ctrl_next(logic [31:0] cur, int al, logic [31:0] wd);
    logic [31:0] n;
    case (al)
      0: n = wd;
      1: n = cur | wd;
      2: n = cur & ~wd;
      default: n = cur;
    endcase
    n &= 32'hC000_01F7;
    if (cur[31] | cur[30]) n = {n[31:30], cur[29:0]};
    return n;
  endfunction

  function automatic logic [31:0] stat_exp();
    return {8'h0, 8'(m_rxn), 8'(m_txn), 5'h0, m_of, m_uf, m_ctrl[0] | eng_active};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    bus_rd(6'h00, r); chk("R1 ctrl", r, 32'hC000_0000);
    bus_rd(6'h10, r); chk("R1 status", r, 0);
    chk("R1 irq/clk_en/eng_rst", {29'h0, irq, clk_en, eng_rst}, 32'h1);

    // R3 locked control write, R12 locked data access
    bus_wr(6'h00, 32'hC000_01F7);
    bus_rd(6'h00, r); chk("R3 locked write", r, 32'hC000_0000);
    push_rx(32'h1111_2222);
    bus_wr(6'h20, 32'hDEAD_0001);
    bus_rd(6'h20, r); chk("R12 locked read", r, 0);
    bus_rd(6'h10, r); chk("R12 locked push", r, 0);

    // R2 aliases
    bus_wr(6'h08, 32'hC000_0000);
    bus_rd(6'h00, r); chk("R2 clear alias", r, 0);
    chk("R11 clk_en/eng_rst", {30'h0, clk_en, eng_rst}, 32'h2);
    bus_wr(6'h04, 32'h0000_0005);
    bus_rd(6'h00, r); chk("R2 set alias", r, 32'h5);
    chk("R11 run_o", {31'h0, run}, 1);
    bus_rd(6'h10, r); chk("R4 busy from run", r, 1);
    bus_wr(6'h08, 32'h1);
    bus_rd(6'h10, r); chk("R4 idle", r, 0);
    eng_active = 1;
    bus_rd(6'h10, r); chk("R4 busy from engine", r, 1);
    eng_active = 0;
    bus_wr(6'h0C, 32'hFFFF_FFFF);
    bus_rd(6'h00, r); chk("R2 reserved alias", r, 32'h4);
    bus_wr(6'h00, 32'hFFFF_FE0A & 32'h3FFF_FFFF);
    bus_rd(6'h00, r); chk("R2 reserved bits", r, 32'h0000_0002);

    // R11 field outputs, R10 frame words
    bus_wr(6'h00, 32'h1C2);
    chk("R11 fields", {27'h0, rx_mode, run, bclk_edge, frame_pol, data_delay}, 32'h17);
    chk("R10 16-bit", {30'h0, frame_words}, 1);
    bus_wr(6'h00, 32'h10);
    chk("R10 20-bit", {28'h0, word_len, frame_words}, 32'h6);
    bus_wr(6'h00, 32'h20);
    chk("R10 24-bit", {28'h0, word_len, frame_words}, 32'hA);
    bus_wr(6'h00, 32'h30);
    chk("R10 reserved code", {30'h0, frame_words}, 2);
    bus_wr(6'h00, 32'h4);

    // R7 transmit order, R5 underflow, R6 irq
    bus_wr(6'h20, 32'hA1); bus_wr(6'h20, 32'hA2); bus_wr(6'h20, 32'hA3);
    bus_rd(6'h10, r); chk("R7 tx level", r, 32'h300);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk); chk("R7 tx order", tx_data, 32'hA0 + i);
      pop_tx();
    end
    chk("R7 empty head", tx_data, 0);
    pop_tx();
    bus_rd(6'h10, r); chk("R5 underflow set", r, 32'h2);
    chk("R6 irq on", {31'h0, irq}, 1);
    bus_wr(6'h10, 32'h2);
    bus_rd(6'h10, r); chk("R5 plain write no effect", r, 32'h2);
    bus_wr(6'h14, 32'h6);
    bus_rd(6'h10, r); chk("R5 set write no effect", r, 32'h2);
    bus_wr(6'h18, 32'h2);
    bus_rd(6'h10, r); chk("R5 clear", r, 0);
    chk("R6 irq off", {31'h0, irq}, 0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 6'h18; bus_wdata = 32'h2; tx_pop = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; tx_pop = 0;
    bus_rd(6'h10, r); chk("R5 set beats clear", r, 32'h2);
    bus_wr(6'h18, 32'h2);

    // R8 receive, overflow
    for (int i = 0; i <= D; i++) push_rx(32'hB0 + i);
    bus_rd(6'h10, r); chk("R8 rx level and R5 overflow", r, (D << 16) | 4);
    chk("R6 irq overflow", {31'h0, irq}, 1);
    for (int i = 0; i < D; i++) begin
      bus_rd(6'h20, r); chk("R8 rx order", r, 32'hB0 + i);
    end
    bus_rd(6'h20, r); chk("R8 empty read", r, 0);

    // R7 full drop, R9 flush
    for (int i = 0; i <= D; i++) bus_wr(6'h20, 32'hC0 + i);
    bus_rd(6'h10, r); chk("R7 tx full", r, (D << 8) | 4);
    for (int i = 0; i < D; i++) begin
      @(negedge clk); chk("R7 full order", tx_data, 32'hC0 + i);
      pop_tx();
    end
    for (int i = 0; i < 3; i++) bus_wr(6'h20, 32'hE0 + i);
    bus_wr(6'h04, 32'h8000_0000);
    bus_rd(6'h10, r); chk("R9 flush", r, 0);
    bus_wr(6'h08, 32'h8000_0000);
    bus_rd(6'h00, r); chk("R9 ctrl after", r, 32'h4);

    // constrained random phase
    bus_wr(6'h00, 32'h0);
    m_ctrl = 0; m_txn = 0; m_rxn = 0; m_uf = 0; m_of = 0;
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: begin
          int al; logic [31:0] wd;
          al = int'($urandom % 4);
          wd = $urandom;
          if ($urandom % 4 != 0) wd[31:30] = 2'b00;
          bus_wr(6'(al << 2), wd);
          m_ctrl = ctrl_next(m_ctrl, al, wd);
          if (m_ctrl[31]) begin m_txn = 0; m_rxn = 0; m_uf = 0; m_of = 0; end
          @(negedge clk);
        end
        1: begin bus_rd(6'h00, r); chk("R2 random ctrl", r, m_ctrl); end
        2: begin
          logic [31:0] wd; wd = $urandom;
          bus_wr(6'h20, wd);
          if (!(m_ctrl[31] | m_ctrl[30]) && m_txn < D) begin m_tx[m_txn] = wd; m_txn++; end
        end
        3: begin
          @(negedge clk);
          chk("R7 random head", tx_data, m_txn > 0 ? m_tx[0] : 32'h0);
          pop_tx();
          if (m_txn > 0) begin
            for (int k = 0; k < D - 1; k++) m_tx[k] = m_tx[k+1];
            m_txn--;
          end else if (!m_ctrl[31]) m_uf = 1;
        end
        4: begin
          logic [31:0] d; d = $urandom;
          push_rx(d);
          if (!m_ctrl[31]) begin
            if (m_rxn < D) begin m_rx[m_rxn] = d; m_rxn++; end
            else m_of = 1;
          end
        end
        5: begin
          logic [31:0] e;
          e = (!(m_ctrl[31] | m_ctrl[30]) && m_rxn > 0) ? m_rx[0] : 32'h0;
          bus_rd(6'h20, r); chk("R8 random read", r, e);
          if (!(m_ctrl[31] | m_ctrl[30]) && m_rxn > 0) begin
            for (int k = 0; k < D - 1; k++) m_rx[k] = m_rx[k+1];
            m_rxn--;
          end
        end
        6: begin
          bus_rd(6'h10, r); chk("R5 random status", r, stat_exp());
          chk("R6 random irq", {31'h0, irq}, {31'h0, m_ctrl[2] & (m_uf | m_of)});
        end
        default: begin
          logic [31:0] wd; wd = $urandom;
          bus_wr(6'h18, wd);
          if (wd[1]) m_uf = 0;
          if (wd[2]) m_of = 0;
        end
      endcase
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule